// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer with Capture

This block is a 16-bit up-counter with a 16-bit reload register. In its default mode the whole count advances on a selected enable tick. When it rolls over from its all-ones value it reloads from the reload pair and raises a sticky high overflow flag. Setting the split bit turns it into two independent 8-bit auto-reload timers. In split mode the run bit gates only the upper byte and the lower byte always counts. A capture mode copies the running count into the reload pair on every eighth tick of a slow reference. Each capture sets the high overflow flag.

Software uses a small byte-wide register port: one control register, two count bytes and two reload bytes. Each byte selects its count enable on its own. The choice is either every system clock cycle or a shared external path. That path is the system clock divided by 12, or one of two reference tick inputs divided by 8. The block drives a single interrupt request built from the two overflow flags. The external reference ticks arrive already synchronised as single-cycle pulses.

Top module: `tmr_split_capture`

## Requirements
- R1: After reset every register (control, both count bytes, both reload bytes) reads 0x00 and irq_o is low.
- R2: Register addresses are 0 control, 1 count low byte, 2 count high byte, 3 reload low byte, 4 reload high byte. Addresses 5 to 7 read as zero. The control bits are [7] high flag, [6] low flag, [5] low interrupt enable, [4] capture enable, [3] split, [2] run, [1] source select, [0] external select. All bits are readable and writable.
- R3: With split=0 the count advances once per enabled tick while run=1. A step from 0xFFFF loads the reload pair (capture off) and sets both the high and the low flag.
- R4: With split=1 a step of the low byte from 0xFF loads the reload low byte and sets the low flag. A step of the high byte from 0xFF loads the reload high byte and sets the high flag. In 16-bit mode the low flag also sets whenever the low byte steps from 0xFF.
- R5: Neither flag is cleared by hardware. A flag stays set until software writes 0 to it.
- R6: irq_o is high exactly when the high flag is set, or when both the low flag and the low interrupt enable are set.
- R7: With split=1 the low byte counts regardless of run, and run gates only the high byte. With split=0 and run=0 the count does not change.
- R8: lo_sys_clk_i=1 (hi_sys_clk_i=1) makes the low (high) byte tick on every cycle. When it is 0 the byte ticks on the external path. With external select=0 that path gives one tick per 12 cycles. With external select=1 it gives one tick per 8 ref_b_tick_i pulses (source select=0) or per 8 ref_a_tick_i pulses (source select=1). In 16-bit mode lo_sys_clk_i governs the whole count.
- R9: With capture enable=1, every 8th pulse of the capture reference copies the count into the reload pair and sets the high flag. The capture reference is ref_a_tick_i when source select=0 and ref_b_tick_i when source select=1. The copy takes the count as it was before that cycle's step. The count keeps counting and is not reloaded, and a capture overrides a reload-byte write in the same cycle.
- R10: With capture enable=1 a rollover wraps the stepping part to zero instead of reloading.
- R11: When a control write and a hardware flag set fall in the same cycle, the flag ends set.
- R12: A write to a count byte overrides that byte's own step or reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register select for read and write |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| ref_a_tick_i | input | 1 | Single-cycle pulse of slow reference A |
| ref_b_tick_i | input | 1 | Single-cycle pulse of reference B |
| lo_sys_clk_i | input | 1 | Low byte (whole count in 16-bit mode) ticks every cycle when 1 |
| hi_sys_clk_i | input | 1 | High byte ticks every cycle when 1 (split mode) |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase or counter value shows on the count registers one cycle after the faulty edge. A wrong flag shows on irq_o at once. The reference model is compared against the read port and irq_o on every cycle, and the bench rotates the read address when it is idle, so a diverging register is reported within five cycles. Divider errors only appear as a missing or extra step, so long runs on each clock source let them build into a visible count difference.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_RLD_LO = 3'd3,
    A_RLD_HI = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic hi_flag;
    logic lo_flag;
    logic lo_ie;
    logic cap_en;
    logic split;
    logic run;
    logic src_sel;
    logic ext_sel;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic pulse_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign pulse_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_byte_cnt.sv
module tmr_byte_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic         zero_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] rld_i,
  output logic [W-1:0] cnt_o,
  output logic         max_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign max_o = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (step_i) cnt_q <= load_i ? (zero_i ? '0 : rld_i) : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_split_capture.sv
module tmr_split_capture
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned SYS_DIV = 12,
  parameter int unsigned REF_DIV = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              ref_a_tick_i,
  input  logic              ref_b_tick_i,
  input  logic              lo_sys_clk_i,
  input  logic              hi_sys_clk_i,
  output logic              irq_o
);
  localparam int unsigned NB    = 2;
  localparam int unsigned CNT_W = NB * BYTE_W;

  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  rld_q;
  logic [CNT_W-1:0]  cnt;

  logic wr_ctrl;
  logic wr_cnt  [NB];
  logic wr_rld  [NB];

  assign wr_ctrl   = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_cnt[0] = reg_we_i && (reg_addr_i == A_CNT_LO);
  assign wr_cnt[1] = reg_we_i && (reg_addr_i == A_CNT_HI);
  assign wr_rld[0] = reg_we_i && (reg_addr_i == A_RLD_LO);
  assign wr_rld[1] = reg_we_i && (reg_addr_i == A_RLD_HI);

  // tick sources
  logic sys_pulse, ref_a_pulse, ref_b_pulse;

  tmr_prescale #(.DIV(SYS_DIV)) i_div_sys (
    .clk_i, .rst_ni, .tick_i(1'b1), .pulse_o(sys_pulse)
  );
  tmr_prescale #(.DIV(REF_DIV)) i_div_ref_a (
    .clk_i, .rst_ni, .tick_i(ref_a_tick_i), .pulse_o(ref_a_pulse)
  );
  tmr_prescale #(.DIV(REF_DIV)) i_div_ref_b (
    .clk_i, .rst_ni, .tick_i(ref_b_tick_i), .pulse_o(ref_b_pulse)
  );

  logic ext_tick, cap_tick, cap_evt;
  logic byte_tick [NB];

  // count and capture use opposite references for the same select value
  assign ext_tick     = ctrl_q.ext_sel ? (ctrl_q.src_sel ? ref_a_pulse : ref_b_pulse) : sys_pulse;
  assign cap_tick     = ctrl_q.src_sel ? ref_b_pulse : ref_a_pulse;
  assign cap_evt      = ctrl_q.cap_en & cap_tick;
  assign byte_tick[0] = lo_sys_clk_i | ext_tick;
  assign byte_tick[1] = hi_sys_clk_i | ext_tick;

  // byte counters
  logic              step  [NB];
  logic              load  [NB];
  logic              at_max[NB];
  logic [BYTE_W-1:0] bcnt  [NB];
  logic              full_max, step16;

  assign full_max = at_max[0] & at_max[1];
  assign step16   = ctrl_q.run & byte_tick[0];

  assign step[0] = ctrl_q.split ? byte_tick[0] : step16;
  assign step[1] = ctrl_q.split ? (ctrl_q.run & byte_tick[1]) : (step16 & at_max[0]);
  assign load[0] = ctrl_q.split ? at_max[0] : full_max;
  assign load[1] = ctrl_q.split ? at_max[1] : full_max;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    tmr_byte_cnt #(.W(BYTE_W)) i_cnt (
      .clk_i,
      .rst_ni,
      .step_i (step[g]),
      .load_i (load[g]),
      .zero_i (ctrl_q.cap_en),
      .wr_i   (wr_cnt[g]),
      .wdata_i(reg_wdata_i),
      .rld_i  (rld_q[g*BYTE_W +: BYTE_W]),
      .cnt_o  (bcnt[g]),
      .max_o  (at_max[g])
    );
    assign cnt[g*BYTE_W +: BYTE_W] = bcnt[g];
  end

  logic set_lo, set_hi;
  assign set_lo = step[0] & at_max[0];
  assign set_hi = (step[1] & at_max[1]) | cap_evt;

  // hardware flag set wins over a same-cycle software write
  always_comb begin
    ctrl_d         = wr_ctrl ? ctrl_t'(reg_wdata_i[7:0]) : ctrl_q;
    ctrl_d.hi_flag = ctrl_d.hi_flag | set_hi;
    ctrl_d.lo_flag = ctrl_d.lo_flag | set_lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q <= '0;
    end else if (cap_evt) begin
      rld_q <= cnt;
    end else begin
      if (wr_rld[0]) rld_q[0 +: BYTE_W]      <= reg_wdata_i;
      if (wr_rld[1]) rld_q[BYTE_W +: BYTE_W] <= reg_wdata_i;
    end
  end

  assign irq_o = ctrl_q.hi_flag | (ctrl_q.lo_flag & ctrl_q.lo_ie);

  always_comb begin
    case (reg_addr_i)
      A_CTRL:   reg_rdata_o = BYTE_W'(ctrl_q);
      A_CNT_LO: reg_rdata_o = bcnt[0];
      A_CNT_HI: reg_rdata_o = bcnt[1];
      A_RLD_LO: reg_rdata_o = rld_q[0 +: BYTE_W];
      A_RLD_HI: reg_rdata_o = rld_q[BYTE_W +: BYTE_W];
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_split_capture_chk.sv
module tmr_split_capture_chk
  import tmr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic                reg_we_i,
  input logic                lo_sys_clk_i,
  input logic [7:0]          ctrl_i,
  input logic [2*BYTE_W-1:0] cnt_i,
  input logic [2*BYTE_W-1:0] rld_i,
  input logic                irq_o
);
  logic wr_ctrl, wr_lo, wr_hi;
  assign wr_ctrl = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_lo   = reg_we_i && (reg_addr_i == A_CNT_LO);
  assign wr_hi   = reg_we_i && (reg_addr_i == A_CNT_HI);

  a_r3_wrap16: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[3] && ctrl_i[2] && !ctrl_i[4] && lo_sys_clk_i && (&cnt_i) && !wr_lo && !wr_hi)
    |=> (cnt_i == $past(rld_i)) && ctrl_i[7] && ctrl_i[6]);

  a_r7_lo_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[3] && lo_sys_clk_i && !wr_lo && !(&cnt_i[BYTE_W-1:0]))
    |=> cnt_i[BYTE_W-1:0] == BYTE_W'($past(cnt_i[BYTE_W-1:0]) + 1'b1));

  a_r7_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[3] && !ctrl_i[2] && !wr_hi) |=> $stable(cnt_i[2*BYTE_W-1:BYTE_W]));

  a_r5_hi_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[7] && !wr_ctrl) |=> ctrl_i[7]);

  a_r5_lo_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[6] && !wr_ctrl) |=> ctrl_i[6]);

  a_r6_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[7] && !(ctrl_i[6] && ctrl_i[5])) |-> !irq_o);
endmodule

bind tmr_split_capture tmr_split_capture_chk #(.BYTE_W(BYTE_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .lo_sys_clk_i(lo_sys_clk_i),
  .ctrl_i      (ctrl_q),
  .cnt_i       (cnt),
  .rld_i       (rld_q),
  .irq_o       (irq_o)
);

// File: tb/test_tmr_split_capture.sv
module test_tmr_split_capture;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ref_a = 1'b0, ref_b = 1'b0;
  logic       lo_sel = 1'b1, hi_sel = 1'b1;
  logic       irq;

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit ref_a_on = 0, ref_b_on = 0;
  int cyc = 0, rr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_split_capture i_tmr_split_capture (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ref_a_tick_i(ref_a),
    .ref_b_tick_i(ref_b), .lo_sys_clk_i(lo_sel), .hi_sys_clk_i(hi_sel),
    .irq_o(irq)
  );

  // reference model state
  int m_ctrl, m_cnt, m_rld, m_d12, m_da, m_db;

  function automatic int mread(int a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt & 255;
      2: return (m_cnt >> 8) & 255;
      3: return m_rld & 255;
      4: return (m_rld >> 8) & 255;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_cnt = 0; m_rld = 0; m_d12 = 0; m_da = 0; m_db = 0;
    end else begin : upd
      bit sp, pa, pb, ext, capt, lt, ht, shi, slo, cap, run, split;
      int lo, hi, ncnt, nrld;
      sp = (m_d12 == 11);
      pa = ref_a && (m_da == 7);
      pb = ref_b && (m_db == 7);
      m_d12 = (m_d12 + 1) % 12;
      if (ref_a) m_da = (m_da + 1) % 8;
      if (ref_b) m_db = (m_db + 1) % 8;
      cap = m_ctrl[4]; split = m_ctrl[3]; run = m_ctrl[2];
      ext  = m_ctrl[0] ? (m_ctrl[1] ? pa : pb) : sp;
      capt = m_ctrl[1] ? pb : pa;
      lt = lo_sel || ext;
      ht = hi_sel || ext;
      shi = 0; slo = 0;
      ncnt = m_cnt; nrld = m_rld;
      if (!split) begin
        if (run && lt) begin
          if ((m_cnt & 255) == 255) slo = 1;
          if (m_cnt == 65535) begin
            ncnt = cap ? 0 : m_rld; shi = 1;
          end else ncnt = m_cnt + 1;
        end
      end else begin
        lo = m_cnt & 255; hi = (m_cnt >> 8) & 255;
        if (lt) begin
          if (lo == 255) begin lo = cap ? 0 : (m_rld & 255); slo = 1; end
          else lo = lo + 1;
        end
        if (run && ht) begin
          if (hi == 255) begin hi = cap ? 0 : ((m_rld >> 8) & 255); shi = 1; end
          else hi = hi + 1;
        end
        ncnt = (hi << 8) | lo;
      end
      if (cap && capt) begin nrld = m_cnt; shi = 1; end
      if (we) begin
        case (addr)
          0: m_ctrl = wdata;
          1: ncnt = (ncnt & 'hFF00) | wdata;
          2: ncnt = (ncnt & 'h00FF) | (wdata << 8);
          3: if (!(cap && capt)) nrld = (nrld & 'hFF00) | wdata;
          4: if (!(cap && capt)) nrld = (nrld & 'h00FF) | (wdata << 8);
          default: ;
        endcase
      end
      if (shi) m_ctrl = m_ctrl | 'h80;
      if (slo) m_ctrl = m_ctrl | 'h40;
      m_cnt = ncnt; m_rld = nrld;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(cur_req, int'(rdata), mread(int'(addr)));
      chk(cur_req, int'(irq), int'(m_ctrl[7] || (m_ctrl[6] && m_ctrl[5])));
    end
  end

  // reference tick patterns
  always @(negedge clk) begin
    cyc++;
    ref_a = ref_a_on && (cyc % 3 == 0);
    ref_b = ref_b_on && (cyc % 2 == 0);
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); we = 0; addr = 3'(rr); rr = (rr + 1) % 5;
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; addr = 3'(a); wdata = 8'(d);
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); we = 0; addr = 3'(a);
    #1 v = int'(rdata);
  endtask

  task automatic report();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 5; a++) begin rd(a, v); chk("R1", v, 0); end
    chk("R1", int'(irq), 0);

    // R2 register map
    cur_req = "R2";
    wr(3, 'h34); wr(4, 'h12); wr(0, 'h20);
    rd(3, v); chk("R2", v, 'h34);
    rd(4, v); chk("R2", v, 'h12);
    rd(0, v); chk("R2", v, 'h20);
    rd(5, v); chk("R2", v, 0);
    wr(0, 0);

    // R3 16-bit rollover and reload
    cur_req = "R3";
    wr(1, 'hF8); wr(2, 'hFF); wr(0, 'h04);
    idle(12);
    rd(0, v); chk("R3", v & 'hC0, 'hC0);
    chk("R6", int'(irq), 1);
    rd(2, v); chk("R3", v, 'h12);
    // R5 software clear
    cur_req = "R5";
    wr(0, 'h04); rd(0, v); chk("R5", v, 'h04);
    // R7 stopped 16-bit counter holds
    cur_req = "R7";
    wr(0, 0); idle(2); rd(1, v); idle(6);
    begin int v2; rd(1, v2); chk("R7", v2, v); end

    // R6 low flag gated by enable
    cur_req = "R6";
    wr(0, 'h40); idle(1); chk("R6", int'(irq), 0);
    wr(0, 'h60); idle(1); chk("R6", int'(irq), 1);
    wr(0, 0);

    // R4/R7 split mode
    cur_req = "R4";
    wr(3, 'hF0); wr(4, 'hFC); wr(1, 'hFA); wr(2, 'hFD); wr(0, 'h08);
    idle(30);
    rd(2, v); chk("R7", v, 'hFD);
    rd(0, v); chk("R4", v & 'hC0, 'h40);
    wr(0, 'h0C); idle(10);
    rd(0, v); chk("R4", v & 'h80, 'h80);
    wr(0, 0);

    // R8 clock sources
    cur_req = "R8";
    lo_sel = 0; hi_sel = 0;
    wr(1, 0); wr(2, 0); wr(0, 'h04);
    idle(120);
    rd(1, v); chk("R8", v, 10);
    ref_b_on = 1; wr(0, 'h05); idle(100);
    rd(1, v); chk("R8", v, mread(1));
    ref_a_on = 1; wr(0, 'h07); idle(100);
    rd(1, v); chk("R8", v, mread(1));
    wr(0, 0); lo_sel = 1; hi_sel = 1;

    // R9 capture on reference A
    cur_req = "R9";
    wr(1, 0); wr(2, 0); wr(3, 0); wr(4, 0); wr(0, 'h14);
    idle(60);
    rd(0, v); chk("R9", v & 'h80, 'h80);
    rd(3, v); chk("R9", v, mread(3));
    chk("R9", int'(v != 0), 1);

    // R10 wrap to zero in capture mode
    cur_req = "R10";
    wr(0, 'h10); wr(1, 'hFE); wr(2, 'hFF); wr(0, 'h14);
    idle(2);
    rd(1, v); chk("R10", v, 0);

    // R11 hardware set beats software clear
    cur_req = "R11";
    ref_a_on = 0; ref_b_on = 0;
    wr(0, 0); wr(1, 'hFE); wr(2, 'hFF); wr(0, 'h04);
    idle(1);
    wr(0, 'h04);
    rd(0, v); chk("R11", v, 'hC4);

    // R12 count write overrides step
    cur_req = "R12";
    wr(1, 'h80);
    rd(1, v); chk("R12", v, 'h80);
    wr(0, 0); idle(5);
    report();
  end
endmodule